// File: doc/BRIEF.md
# Balanced-Duty Integer Clock Divider

This block derives a slower clock from an input clock by a fixed integer ratio chosen at elaboration time. Unlike a plain counter divider, which can only produce a balanced waveform for even ratios, it advances its phase on both input edges. An odd ratio therefore still gives an output that stays high for exactly half of its period.

Phase is tracked by a counter clocked on the rising edge. A retiming flop clocked on the falling edge supplies the extra half cycle that odd ratios need. For even ratios the output comes straight from a rising-edge flop. For odd ratios the output is the AND of the rising-edge flop and the falling-edge flop. Neither form has a combinational path from the input clock to the output.

A synchronous active-high reset, sampled on the rising edge, realigns the phase. Edges are counted from the last rising edge that sees reset high. That edge is edge 0, the following falling edge is edge 1, and so on. The ratio must be 2 or more.

Top module: `dual_edge_clk_div`

## Requirements
- R1: For a ratio N, the output period is exactly N input clock periods.
- R2: For odd N, the output stays high for exactly N input half-periods, which is 50% duty.
- R3: For even N, the output stays high for exactly N input half-periods, which is 50% duty.
- R4: After reset is released, the output first rises at edge N, where edge 0 is the last rising edge that sampled reset high and every later rising or falling edge adds one.
- R5: The output falls at edge 2N and then stays low for exactly N input half-periods before it rises again; the pattern repeats every 2N edges.
- R6: On a rising edge that samples reset high, the output goes low, and it stays low for as long as reset is held.
- R7: A reset applied at any phase restarts the sequence, so the first rise after release follows R4 whatever the earlier phase was.
- R8: For even N, both output transitions happen on rising input edges. For odd N, the output rises on a falling input edge and falls on a rising input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset, sampled on the rising edge of clk_i |
| clk_o | output | 1 | Divided clock output |

## Verification
The divider is tried with ratios 2, 3, 4 and 5 running side by side from one input clock. Each output is timed to half-cycle resolution: its high time, low time and period, and whether each transition lands on a rising or a falling input edge. The odd ratios tell a true dual-edge divider apart from a skewed single-edge divider, whose high and low times would differ by one full input cycle. A reset released at a known edge, and a second reset asserted in the middle of a waveform, show whether the first rise lands exactly N edges after the reset edge, which exposes an off-by-one in the counter or in the thresholds.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // How the two phase flops are merged into the output
    typedef enum logic {
        MERGE_RISE_ONLY  = 1'b0,
        MERGE_BOTH_EDGES = 1'b1
    } merge_mode_e;

    // Rising-edge phase count from which the rising-domain flop is high
    function automatic int unsigned high_threshold(input int unsigned ratio);
        return ratio / 2;
    endfunction

    function automatic merge_mode_e merge_mode(input int unsigned ratio);
        return (ratio % 2 == 1) ? MERGE_BOTH_EDGES : MERGE_RISE_ONLY;
    endfunction

    function automatic int unsigned count_width(input int unsigned ratio);
        return (ratio < 2) ? 1 : $clog2(ratio);
    endfunction

endpackage

// File: rtl/cdiv_rise_phase.sv
`timescale 1ns/1ps
module cdiv_rise_phase
    import clkdiv_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic high_o
);
    localparam int unsigned CW = count_width(DIV_RATIO);
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] THRESH = CW'(high_threshold(DIV_RATIO));

    logic [CW-1:0] phase_q;
    logic [CW-1:0] phase_d;

    always_comb begin
        if (phase_q == LAST) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
            high_o  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            high_o  <= (phase_d >= THRESH);
        end
    end
endmodule

// File: rtl/cdiv_fall_retime.sv
`timescale 1ns/1ps
module cdiv_fall_retime (
    input  logic clk_i,
    input  logic rst_i,
    input  logic high_i,
    output logic high_o
);
    // Delays the rising-domain level by half an input cycle
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            high_o <= 1'b0;
        end else begin
            high_o <= high_i;
        end
    end
endmodule

// File: rtl/cdiv_out_merge.sv
`timescale 1ns/1ps
module cdiv_out_merge
    import clkdiv_pkg::*;
#(
    parameter merge_mode_e MODE = MERGE_BOTH_EDGES
) (
    input  logic rise_high_i,
    input  logic fall_high_i,
    output logic clk_o
);
    generate
        if (MODE == MERGE_BOTH_EDGES) begin : g_both
            // Each input of the AND changes only while the other holds it open
            assign clk_o = rise_high_i & fall_high_i;
        end else begin : g_rise
            logic unused_fall;
            assign unused_fall = fall_high_i;
            assign clk_o = rise_high_i;
        end
    endgenerate
endmodule

// File: rtl/dual_edge_clk_div.sv
`timescale 1ns/1ps
module dual_edge_clk_div
    import clkdiv_pkg::*;
#(
    parameter int unsigned DIV_RATIO = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic clk_o
);
    localparam merge_mode_e MODE = merge_mode(DIV_RATIO);

    logic rise_high;
    logic fall_high;

    cdiv_rise_phase #(.DIV_RATIO(DIV_RATIO)) u_rise (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .high_o (rise_high)
    );

    generate
        if (MODE == MERGE_BOTH_EDGES) begin : g_fall
            cdiv_fall_retime u_fall (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .high_i (rise_high),
                .high_o (fall_high)
            );
        end else begin : g_nofall
            assign fall_high = 1'b0;
        end
    endgenerate

    cdiv_out_merge #(.MODE(MODE)) u_merge (
        .rise_high_i (rise_high),
        .fall_high_i (fall_high),
        .clk_o       (clk_o)
    );
endmodule

// File: rtl/dual_edge_clk_div_checker.sv
`timescale 1ns/1ps
module dual_edge_clk_div_checker #(
    parameter int unsigned DIV_RATIO = 3
) (
    input logic clk_i,
    input logic rst_i,
    input logic clk_o
);
    // clk_o sampled at each rising input edge: highs run ceil(N/2), lows floor(N/2)
    localparam int unsigned HI_LEN = (DIV_RATIO + 1) / 2;
    localparam int unsigned LO_LEN = DIV_RATIO / 2;
    localparam int unsigned RW = $clog2(DIV_RATIO + 2);

    logic [RW-1:0] hi_run;
    logic [RW-1:0] lo_run;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run <= '0;
            lo_run <= '0;
        end else if (clk_o) begin
            lo_run <= '0;
            if (hi_run != RW'(DIV_RATIO + 1)) hi_run <= hi_run + RW'(1);
        end else begin
            hi_run <= '0;
            if (lo_run != RW'(DIV_RATIO + 1)) lo_run <= lo_run + RW'(1);
        end
    end

    // R6: output low right after reset is lifted
    p_low_after_reset_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !clk_o);

    // R2 / R3: high run never longer than its share
    p_high_run_max_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (hi_run == RW'(HI_LEN)) |-> !clk_o);

    // R5: low run never longer than its share
    p_low_run_max_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (lo_run == RW'(LO_LEN)) |-> clk_o);

    // R1: a completed high run has full length
    p_high_run_full_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clk_o && hi_run != '0) |-> (hi_run == RW'(HI_LEN)));

    // R4: a completed low run (including the first after reset) has full length
    p_low_run_full_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (clk_o && lo_run != '0) |-> (lo_run == RW'(LO_LEN)));
endmodule

bind dual_edge_clk_div dual_edge_clk_div_checker #(.DIV_RATIO(DIV_RATIO)) chk_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clk_o (clk_o)
);

// File: tb/dual_edge_clk_div_tb.sv
`timescale 1ns/1ps
module dual_edge_clk_div_tb_top;
    localparam real HALF = 4.0;  // 125 MHz

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic out2, out3, out4, out5;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    realtime t_rel_edge = 0.0;

    always #(HALF) clk = ~clk;

    dual_edge_clk_div #(.DIV_RATIO(2)) dut_r2_i (.clk_i(clk), .rst_i(rst), .clk_o(out2));
    dual_edge_clk_div #(.DIV_RATIO(3)) dut_i    (.clk_i(clk), .rst_i(rst), .clk_o(out3));
    dual_edge_clk_div #(.DIV_RATIO(4)) dut_r4_i (.clk_i(clk), .rst_i(rst), .clk_o(out4));
    dual_edge_clk_div #(.DIV_RATIO(5)) dut_r5_i (.clk_i(clk), .rst_i(rst), .clk_o(out5));

    function automatic logic out_of(input int idx);
        case (idx)
            0: return out2;
            1: return out3;
            2: return out4;
            default: return out5;
        endcase
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Polls at half-ns offsets; returns time at which output reached val
    task automatic wait_level(input int idx, input logic val, output realtime t);
        int guard = 0;
        while (out_of(idx) !== val && guard < 2000) begin
            #1;
            guard++;
        end
        t = $realtime;
    endtask

    // Release reset half a ns after a rising edge that still sampled it high
    task automatic release_reset();
        @(posedge clk);
        t_rel_edge = $realtime;
        #0.5;
        rst = 1'b0;
    endtask

    task automatic t_reset_hold();
        repeat (3) @(posedge clk);
        #0.5;
        for (int i = 0; i < 4; i++)
            check_int("R6", $sformatf("out[%0d] during reset", i), int'(out_of(i)), 0);
    endtask

    task automatic t_first_rise(input string req);
        for (int i = 0; i < 4; i++) begin
            realtime t;
            int n = i + 2;
            wait_level(i, 1'b1, t);
            check_int(req, $sformatf("ratio %0d first rise delay ps", n),
                      int'((t - t_rel_edge - 0.5) * 1000.0), int'(n * HALF * 1000.0));
        end
    endtask

    task automatic t_wave(input int idx);
        realtime tf1, tr1, tf2, tr2;
        int n = idx + 2;
        string rhi = (n % 2 == 1) ? "R2" : "R3";
        wait_level(idx, 1'b0, tf1);
        wait_level(idx, 1'b1, tr1);
        wait_level(idx, 1'b0, tf2);
        wait_level(idx, 1'b1, tr2);
        check_int(rhi, $sformatf("ratio %0d high time ns", n), int'(tf2 - tr1), n * 4);
        check_int("R5", $sformatf("ratio %0d low time ns", n), int'(tr2 - tf2), n * 4);
        check_int("R1", $sformatf("ratio %0d period ns", n), int'(tr2 - tr1), n * 8);
        // rising input edges sit at 4 mod 8 ns, falling at 0 mod 8 ns
        check_int("R8", $sformatf("ratio %0d rise edge phase", n),
                  int'(tr1 - 0.5) % 8, (n % 2 == 1) ? 0 : 4);
        check_int("R8", $sformatf("ratio %0d fall edge phase", n),
                  int'(tf2 - 0.5) % 8, 4);
    endtask

    task automatic t_mid_reset();
        repeat (7) @(posedge clk);
        #0.5;
        rst = 1'b1;
        @(posedge clk);
        #0.5;
        for (int i = 0; i < 4; i++)
            check_int("R6", $sformatf("out[%0d] after mid-run reset", i), int'(out_of(i)), 0);
        @(posedge clk);
        release_reset();
    endtask

    initial begin
        t_reset_hold();
        release_reset();
        t_first_rise("R4");
        for (int i = 0; i < 4; i++) t_wave(i);
        t_mid_reset();
        t_first_rise("R7");
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule